// File: doc/BRIEF.md
# Bit-Serial Adding Accumulator

This block adds an operand word into a running total one bit per clock. The operand lives in a W-bit shift register and the running total in a (W+1)-bit accumulator shift register. Both registers present their least significant bit to a single full adder. The carry is held in a flip-flop between steps. Each sum bit is pushed back in at the top of the accumulator, so the accumulator rotates once around through the adder.

The accumulator is one bit wider than the operand, so the carry out of the top operand bit becomes part of the stored total. The operand register rotates during the W data steps and then holds, so it ends in its original value and the same operand can be added again with another start pulse. With the default W = 8, a pair of 8-bit values gives an exact 9-bit sum. Repeated starts sum a series modulo 2^(W+1), and the accumulator's top bit takes part in later additions.

Top module: `serial_accum`

## Requirements
- R1: After reset, acc_out is zero, busy and done are low, and the operand register holds zero, so an addition leaves acc_out unchanged.
- R2: While busy is low and start is low, acc_load high for one clock loads acc_in into the accumulator, and acc_out shows it from the next cycle. opnd_load high loads opnd_in into the operand register in the same way.
- R3: When done is high, acc_out equals (accumulator value at start + operand) mod 2^(W+1), with the operand zero-extended. When the accumulator's top bit was 0, bit W of the result is the carry out of the operand-width sum.
- R4: A start pulse sampled while busy is low raises busy at that edge. done is high for exactly one cycle, after the (W+1)th rising edge following the start edge. busy falls at that same edge.
- R5: At the end of an addition the operand register holds its value from before the addition. A further start therefore adds the same operand again.
- R6: A start pulse sampled while busy is high has no effect on the result or on the timing of done.
- R7: acc_load and opnd_load are ignored while busy is high and in the cycle where start is accepted.
- R8: The carry flip-flop is cleared at every accepted start. A carry out of bit W is dropped, so an all-ones accumulator plus 1 gives zero, and the next addition begins with no carry.
- R9: While busy is low and acc_load is low, acc_out stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an addition (taken only when idle) |
| acc_load | input | 1 | Parallel load of the accumulator when idle |
| acc_in | input | W+1 | Accumulator load value |
| opnd_load | input | 1 | Parallel load of the operand when idle |
| opnd_in | input | W | Operand load value |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| acc_out | output | W+1 | Parallel view of the accumulator |

## Verification
The assertions assume that start and the load strobes are synchronous levels that are held for whole cycles and are free of X after reset. The sum and operand-preservation checks also assume the accumulator is not touched between an accepted start and done. The stimulus changes inputs only on falling edges and holds each strobe for one full cycle. It deliberately pulses start and both loads in the middle of a run, and relies on the block to ignore them there.

// File: rtl/sa_pkg.sv
package sa_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic logic fa_sum(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_carry(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sa_full_add.sv
module sa_full_add
    import sa_pkg::*;
(
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    always_comb begin
        sum  = fa_sum(a, b, cin);
        cout = fa_carry(a, b, cin);
    end
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_out
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } sr_t;

    sr_t sr_d, sr_q;
    logic [WIDTH-1:0] shifted;

    generate
        if (WIDTH == 1) begin : g_single
            assign shifted = ser_in;
        end else begin : g_multi
            assign shifted = {ser_in, sr_q.bits[WIDTH-1:1]};
        end
    endgenerate

    always_comb begin
        sr_d = sr_q;
        if (shift_en) begin
            sr_d.bits = shifted;
        end else if (load_en) begin
            sr_d.bits = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign par_out = sr_q.bits;
    assign ser_out = sr_q.bits[0];

    // R3: a shift moves every bit down by one and puts the serial input at the top
    p_shift_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> par_out[WIDTH-1] == $past(ser_in));

    // R9: with no shift and no load the register holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(par_out));
endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
    import sa_pkg::*;
#(
    parameter int STEPS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done,
    output logic opnd_step
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        accept   = (c_q.state == SEQ_IDLE) && start;
        case (c_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    c_d.state = SEQ_RUN;
                    c_d.cnt   = '0;
                end
            end
            default: begin
                if (c_q.cnt == LAST_STEP) begin
                    c_d.state = SEQ_IDLE;
                    c_d.done  = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: SEQ_IDLE, cnt: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign busy      = (c_q.state == SEQ_RUN);
    assign done      = c_q.done;
    assign opnd_step = busy && (c_q.cnt < LAST_STEP);

    // R4: done lasts a single cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done only follows a busy cycle, and busy is low with it
    p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R6: a run begins only from an idle start request
    p_run_needs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4: the step counter never passes the final step
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (c_q.cnt <= LAST_STEP));
endmodule

// File: rtl/serial_accum.sv
module serial_accum #(
    parameter int OPW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         acc_load,
    input  logic [OPW:0] acc_in,
    input  logic         opnd_load,
    input  logic [OPW-1:0] opnd_in,
    output logic         busy,
    output logic         done,
    output logic [OPW:0] acc_out
);
    localparam int ACCW  = OPW + 1;
    localparam int STEPS = OPW + 1;

    typedef struct packed {
        logic carry;
    } dp_t;

    dp_t dp_d, dp_q;

    logic accept, opnd_step, idle_load;
    logic acc_bit, opnd_bit, add_b, sum_bit, carry_out;
    logic [OPW-1:0] opnd_q;

    sa_seq_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .opnd_step (opnd_step)
    );

    assign idle_load = !busy && !start;

    sa_shift_reg #(.WIDTH(OPW)) u_opnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (opnd_load && idle_load),
        .load_val (opnd_in),
        .shift_en (opnd_step),
        .ser_in   (opnd_bit),
        .par_out  (opnd_q),
        .ser_out  (opnd_bit)
    );

    sa_shift_reg #(.WIDTH(ACCW)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (acc_load && idle_load),
        .load_val (acc_in),
        .shift_en (busy),
        .ser_in   (sum_bit),
        .par_out  (acc_out),
        .ser_out  (acc_bit)
    );

    assign add_b = opnd_step & opnd_bit;

    sa_full_add u_fa (
        .a    (acc_bit),
        .b    (add_b),
        .cin  (dp_q.carry),
        .sum  (sum_bit),
        .cout (carry_out)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.carry = 1'b0;
        end else if (busy) begin
            dp_d.carry = carry_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    // Checker-side snapshots taken when a run is accepted
    logic [OPW:0]   chk_acc_q;
    logic [OPW-1:0] chk_opnd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_acc_q  <= '0;
            chk_opnd_q <= '0;
        end else if (accept) begin
            chk_acc_q  <= acc_out;
            chk_opnd_q <= opnd_q;
        end
    end

    // R8: every accepted run begins with a clear carry
    p_carry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (dp_q.carry == 1'b0));

    // R3: the finished accumulator holds the wrapped sum
    p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_out == chk_acc_q + ACCW'(chk_opnd_q)));

    // R5: the operand is back in place when the run ends
    p_opnd_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (opnd_q == chk_opnd_q));

    // R9: idle accumulator without a load keeps its value
    p_acc_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !acc_load) |=> $stable(acc_out));

    // R7: the operand register is not loaded during a run
    p_no_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !opnd_step) |=> $stable(opnd_q));
endmodule

// File: tb/serial_accum_bench.sv
module serial_accum_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         acc_load = 1'b0;
    logic [W:0]   acc_in = '0;
    logic         opnd_load = 1'b0;
    logic [W-1:0] opnd_in = '0;
    logic         busy, done;
    logic [W:0]   acc_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    serial_accum #(.OPW(W)) u_serial_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .acc_load  (acc_load),
        .acc_in    (acc_in),
        .opnd_load (opnd_load),
        .opnd_in   (opnd_in),
        .busy      (busy),
        .done      (done),
        .acc_out   (acc_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_acc(input logic [W:0] v);
        @(negedge clk);
        acc_load = 1'b1;
        acc_in   = v;
        @(negedge clk);
        acc_load = 1'b0;
        check(acc_out == v, "R2 acc load", int'(acc_out), int'(v));
    endtask

    task automatic load_opnd(input logic [W-1:0] v);
        @(negedge clk);
        opnd_load = 1'b1;
        opnd_in   = v;
        @(negedge clk);
        opnd_load = 1'b0;
    endtask

    // Runs one addition; poke drives start and both loads in mid-run
    task automatic run_add(input logic [W:0] exp, input string req, input bit poke);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R4 busy after start", int'({busy, done}), 2);
        for (int i = 1; i <= W + 1; i++) begin
            if (poke && i == 3) begin
                start     = 1'b1;
                acc_load  = 1'b1;
                acc_in    = '1;
                opnd_load = 1'b1;
                opnd_in   = 8'h3C;
            end
            @(negedge clk);
            if (poke && i == 3) begin
                start     = 1'b0;
                acc_load  = 1'b0;
                opnd_load = 1'b0;
            end
            if (i <= W) begin
                if (busy !== 1'b1 || done !== 1'b0)
                    check(1'b0, "R4 early done", int'({busy, done}), 2);
            end else begin
                check(busy == 1'b0 && done == 1'b1, "R4 done timing", int'({busy, done}), 1);
            end
        end
        check(acc_out == exp, req, int'(acc_out), int'(exp));
        @(negedge clk);
        check(done == 1'b0, "R4 done one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        check(acc_out == '0 && busy == 1'b0 && done == 1'b0, "R1 reset outputs",
              int'({busy, done, acc_out}), 0);
        load_acc(9'h015);
        run_add(9'h015, "R1 operand zero after reset", 1'b0);
    endtask

    task automatic t_basic;
        logic [W:0]   a;
        logic [W-1:0] b;
        load_acc(9'h0FF); load_opnd(8'hFF);
        run_add(9'h1FE, "R3 carry into top bit", 1'b0);
        load_acc(9'h0A5); load_opnd(8'h5A);
        run_add(9'h0FF, "R3 no carry", 1'b0);
        load_acc(9'h001); load_opnd(8'hFF);
        run_add(9'h100, "R3 rippling carry", 1'b0);
        for (int k = 0; k < 6; k++) begin
            a = (W+1)'($urandom_range(0, 255));
            b = W'($urandom_range(0, 255));
            load_acc(a); load_opnd(b);
            run_add(a + (W+1)'(b), "R3 random operands", 1'b0);
        end
    endtask

    task automatic t_accum;
        logic [W:0] model;
        model = 9'h000;
        load_acc(model); load_opnd(8'hC7);
        for (int k = 0; k < 5; k++) begin
            model = model + 9'h0C7;
            run_add(model, "R5 repeated accumulation", 1'b0);
        end
    endtask

    task automatic t_wrap;
        load_acc(9'h1FF); load_opnd(8'h01);
        run_add(9'h000, "R8 wrap drops carry", 1'b0);
        run_add(9'h001, "R8 fresh carry next run", 1'b0);
    endtask

    task automatic t_busy_poke;
        load_acc(9'h123); load_opnd(8'h42);
        run_add(9'h165, "R6 R7 mid-run start and loads ignored", 1'b1);
        run_add(9'h1A7, "R7 operand unchanged by mid-run load", 1'b0);
    endtask

    task automatic t_load_at_start;
        load_acc(9'h010); load_opnd(8'h05);
        @(negedge clk);
        start     = 1'b1;
        acc_load  = 1'b1;
        acc_in    = 9'h1AA;
        opnd_load = 1'b1;
        opnd_in   = 8'h77;
        @(negedge clk);
        start     = 1'b0;
        acc_load  = 1'b0;
        opnd_load = 1'b0;
        repeat (W + 1) @(negedge clk);
        check(done == 1'b1 && acc_out == 9'h015, "R7 loads ignored at start",
              int'(acc_out), 9'h015);
    endtask

    task automatic t_idle_hold;
        logic [W:0] held;
        held = acc_out;
        opnd_in = 8'hEE;
        repeat (5) @(negedge clk);
        check(acc_out == held, "R9 idle hold", int'(acc_out), int'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_accum;
        t_wrap;
        t_busy_poke;
        t_load_at_start;
        t_idle_hold;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule